// File: doc/BRIEF.md
# I2C Target Byte Responder

This block is the target (slave) side of an I2C bus controller. It watches the open-drain SCL and SDA lines and compares each address frame with a programmed 7-bit device address. On a hit it acknowledges the address and reports it to software. After that it moves one byte at a time and waits for software between bytes. Software sees the last received byte in the upper half of a 16-bit byte buffer and one-cycle event pulses for every step of the exchange.

For a master write, every data byte is acknowledged automatically and announced with a receive pulse. For a master read, the responder holds SCL low until software issues a transmit command together with the byte to send. It then shifts the byte out MSB first and samples the master's acknowledge. An acknowledge parks the bus again, waiting for the next command. A not-acknowledge or a stop condition ends the exchange and releases both lines.

Top module: `i2c_target_resp`

## Requirements
- R1: When an address frame arrives whose upper seven bits equal `dev_addr`, `ev_match` and `ev_rx_done` pulse together for one cycle. `byte_buf[15:8]` then holds the whole frame byte, and the responder pulls SDA low for the ninth (acknowledge) clock. Frame bit 0 is the direction, where 1 means the master reads.
- R2: While `slave_en` is 0 the responder never drives SDA or SCL and raises no event, even when an address matches.
- R3: An address frame that does not match is ignored until the next start condition: no events, SDA not driven, no acknowledge.
- R4: In a master write, each data byte is acknowledged (SDA low on the ninth clock), `ev_rx_done` pulses and the byte appears in `byte_buf[15:8]`.
- R5: In a master read, the responder holds SCL low after the address acknowledge until a one-cycle `tx_go`. It latches `tx_byte` into `byte_buf[7:0]` and sends it MSB first; SCL is released only by `tx_go`, a start, a stop or disable.
- R6: After each transmitted byte, an acknowledge from the master (SDA low on the ninth clock) pulses `ev_tx_ack` and holds SCL low again for the next `tx_go`. A not-acknowledge pulses `ev_tx_nak` and releases both lines with no further byte.
- R7: A stop condition (SDA rising while SCL is high) while enabled pulses `ev_stop` and leaves both lines released.
- R8: A repeated start restarts address reception, so a write followed by a repeated-start read is served correctly.
- R9: The responder changes its SDA drive only while SCL is low, except when releasing on start, stop or disable.
- R10: After reset no line is driven, all events are low and `byte_buf` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Target function enable |
| dev_addr | input | 7 | Own 7-bit device address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_go | input | 1 | One-cycle transmit command |
| tx_byte | input | 8 | Byte to transmit, taken with tx_go |
| byte_buf | output | 16 | [15:8] last received byte, [7:0] last transmitted byte |
| ev_match | output | 1 | Address hit pulse |
| ev_rx_done | output | 1 | Byte received pulse |
| ev_tx_ack | output | 1 | Master acknowledged transmitted byte |
| ev_tx_nak | output | 1 | Master refused transmitted byte |
| ev_stop | output | 1 | Stop condition seen |

## Verification
The assertions check several rules on every cycle. SDA drive may move only while the synchronized SCL is low, and SCL is freed only by a transmit command or by a bus-level release. A disabled responder stays silent, a stop leaves the lines free, an address hit always comes with the acknowledge drive, and a refusal leaves nothing driven. Other behaviour can only be shown by the bench's scenarios driving a full bus master: the byte values, the bit order on the wire, and the event sequence through writes, reads, a refused read, a foreign address and a repeated start.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_DATA,
        PH_WR_ACK,
        PH_RD_WAIT,
        PH_RD_DATA,
        PH_RD_ACK
    } phase_e;

    typedef struct packed {
        logic match;
        logic rx;
        logic ack;
        logic nak;
        logic stop;
    } evt_s;

endpackage

// File: rtl/i2c_target_sync.sv
module i2c_target_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Index STAGES-1 is the synchronized level, index STAGES the previous one.
    localparam int TOP = STAGES;
    localparam int CUR = STAGES - 1;

    logic [TOP:0] scl_d, scl_q;
    logic [TOP:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[TOP-1:0], scl_i};
        sda_d = {sda_q[TOP-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_lvl   = scl_q[CUR];
    assign sda_lvl   = sda_q[CUR];
    assign scl_rise  = scl_q[CUR] & ~scl_q[TOP];
    assign scl_fall  = ~scl_q[CUR] & scl_q[TOP];
    assign start_det = scl_q[CUR] & scl_q[TOP] & ~sda_q[CUR] & sda_q[TOP];
    assign stop_det  = scl_q[CUR] & scl_q[TOP] & sda_q[CUR] & ~sda_q[TOP];

endmodule

// File: rtl/i2c_target_addr.sv
module i2c_target_addr #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] frame,
    input  logic [DATA_W-2:0] own_addr,
    output logic              hit,
    output logic              is_read
);
    // Upper bits carry the address, bit 0 carries the direction (1 = read).
    assign hit     = (frame[DATA_W-1:1] == own_addr);
    assign is_read = frame[0];

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_target_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slv_en,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_hit,
    input  logic              addr_rd,
    input  logic              tx_go,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] frame,
    output logic [DATA_W-1:0] rx_buf,
    output logic [DATA_W-1:0] tx_buf,
    output logic              sda_low,
    output logic              scl_low,
    output evt_s              evt
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rbuf;
        logic [DATA_W-1:0] tbuf;
        logic              sda_low;
        logic              scl_low;
        logic              rd_dir;
        evt_s              ev;
    } core_s;

    core_s d, q;

    always_comb begin
        d    = q;
        d.ev = '0;
        if (!slv_en) begin
            // R2: disabled responder stays off the bus
            d.phase   = PH_IDLE;
            d.bitcnt  = '0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else if (stop_det) begin
            // R7
            d.ev.stop = 1'b1;
            d.phase   = PH_IDLE;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else if (start_det) begin
            // R8: any start, repeated or not, restarts the address phase
            d.phase   = PH_ADDR;
            d.bitcnt  = '0;
            d.sda_low = 1'b0;
            d.scl_low = 1'b0;
        end else begin
            case (q.phase)
                PH_ADDR, PH_WR_DATA: begin
                    if (scl_rise && q.bitcnt != FULL) begin
                        d.shreg  = {q.shreg[DATA_W-2:0], sda_lvl};
                        d.bitcnt = q.bitcnt + ONE;
                    end
                    if (scl_fall && q.bitcnt == FULL) begin
                        if (q.phase == PH_WR_DATA) begin
                            // R4
                            d.ev.rx   = 1'b1;
                            d.rbuf    = q.shreg;
                            d.sda_low = 1'b1;
                            d.phase   = PH_WR_ACK;
                        end else if (addr_hit) begin
                            // R1
                            d.ev.match = 1'b1;
                            d.ev.rx    = 1'b1;
                            d.rbuf     = q.shreg;
                            d.sda_low  = 1'b1;
                            d.rd_dir   = addr_rd;
                            d.phase    = PH_ADDR_ACK;
                        end else begin
                            // R3: foreign address, wait for next start
                            d.phase = PH_IDLE;
                        end
                    end
                end
                PH_ADDR_ACK, PH_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0;
                        d.bitcnt  = '0;
                        if (q.phase == PH_ADDR_ACK && q.rd_dir) begin
                            d.phase   = PH_RD_WAIT;
                            d.scl_low = 1'b1;
                        end else begin
                            d.phase = PH_WR_DATA;
                        end
                    end
                end
                PH_RD_WAIT: begin
                    // R5: SCL held until software arms the byte
                    if (tx_go) begin
                        d.tbuf    = tx_byte;
                        d.shreg   = tx_byte;
                        d.sda_low = ~tx_byte[DATA_W-1];
                        d.scl_low = 1'b0;
                        d.bitcnt  = ONE;
                        d.phase   = PH_RD_DATA;
                    end
                end
                PH_RD_DATA: begin
                    if (scl_fall) begin
                        if (q.bitcnt == FULL) begin
                            d.sda_low = 1'b0;
                            d.phase   = PH_RD_ACK;
                        end else begin
                            d.shreg   = {q.shreg[DATA_W-2:0], 1'b0};
                            d.sda_low = ~q.shreg[DATA_W-2];
                            d.bitcnt  = q.bitcnt + ONE;
                        end
                    end
                end
                PH_RD_ACK: begin
                    // R6
                    if (scl_rise) begin
                        if (!sda_lvl) begin
                            d.ev.ack = 1'b1;
                            d.bitcnt = '0;
                        end else begin
                            d.ev.nak = 1'b1;
                            d.phase  = PH_IDLE;
                        end
                    end else if (scl_fall && q.bitcnt == '0) begin
                        d.phase   = PH_RD_WAIT;
                        d.scl_low = 1'b1;
                    end
                end
                default: begin
                    d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign frame   = q.shreg;
    assign rx_buf  = q.rbuf;
    assign tx_buf  = q.tbuf;
    assign sda_low = q.sda_low;
    assign scl_low = q.scl_low;
    assign evt     = q.ev;

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_low) |-> (!$past(scl_lvl) || $past(stop_det) || $past(start_det) || !$past(slv_en))); // R9

    AST_SCL_FREED_BY_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.scl_low) |-> ($past(tx_go) || $past(stop_det) || $past(start_det) || !$past(slv_en))); // R5

    AST_MATCH_DRIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q.ev.match |-> (q.phase == PH_ADDR_ACK && q.sda_low)); // R1

    AST_NAK_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        q.ev.nak |-> (!q.sda_low && !q.scl_low && q.phase == PH_IDLE)); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> (!q.sda_low && !q.scl_low && q.ev == '0)); // R2

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_en && stop_det) |=> (!q.sda_low && !q.scl_low && q.ev.stop)); // R7

endmodule

// File: rtl/i2c_target_resp.sv
module i2c_target_resp
    import i2c_target_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slave_en,
    input  logic [DATA_W-2:0]   dev_addr,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe,
    output logic                sda_oe,
    input  logic                tx_go,
    input  logic [DATA_W-1:0]   tx_byte,
    output logic [2*DATA_W-1:0] byte_buf,
    output logic                ev_match,
    output logic                ev_rx_done,
    output logic                ev_tx_ack,
    output logic                ev_tx_nak,
    output logic                ev_stop
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic addr_hit, addr_rd;
    logic [DATA_W-1:0] frame, rx_buf, tx_buf;
    evt_s evt;

    i2c_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_addr #(.DATA_W(DATA_W)) u_addr (
        .frame    (frame),
        .own_addr (dev_addr),
        .hit      (addr_hit),
        .is_read  (addr_rd)
    );

    i2c_target_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .slv_en    (slave_en),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_hit  (addr_hit),
        .addr_rd   (addr_rd),
        .tx_go     (tx_go),
        .tx_byte   (tx_byte),
        .frame     (frame),
        .rx_buf    (rx_buf),
        .tx_buf    (tx_buf),
        .sda_low   (sda_oe),
        .scl_low   (scl_oe),
        .evt       (evt)
    );

    assign byte_buf   = {rx_buf, tx_buf};
    assign ev_match   = evt.match;
    assign ev_rx_done = evt.rx;
    assign ev_tx_ack  = evt.ack;
    assign ev_tx_nak  = evt.nak;
    assign ev_stop    = evt.stop;

endmodule

// File: tb/i2c_target_resp_tb.sv
module i2c_target_resp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 10;
    localparam int WD_LIMIT   = 100000;
    localparam int EV_MATCH = 1, EV_RX = 2, EV_ACK = 3, EV_NAK = 4, EV_STOP = 5;

    typedef struct {
        int    code;
        int    data;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_en = 1'b0;
    logic [6:0] dev_addr = 7'h2A;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe;
    logic tx_go = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [15:0] byte_buf;
    logic ev_match, ev_rx_done, ev_tx_ack, ev_tx_nak, ev_stop;

    int checks = 0, errors = 0, cyc = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    bit sda_seen = 1'b0;
    logic prev_sda_oe = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_oe);
    assign sda_bus = !(m_sda_low || sda_oe);

    i2c_target_resp u_dut (
        .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .dev_addr(dev_addr),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tx_go(tx_go), .tx_byte(tx_byte), .byte_buf(byte_buf),
        .ev_match(ev_match), .ev_rx_done(ev_rx_done), .ev_tx_ack(ev_tx_ack),
        .ev_tx_nak(ev_tx_nak), .ev_stop(ev_stop)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_evt(input int code, input int data, input string req);
        exp_t it;
        it.code = code;
        it.data = data;
        it.req  = req;
        exp_q.push_back(it);
    endtask

    task automatic sb_take(input int code, input int data);
        exp_t it;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected event actual=%0d expected=none", code);
        end else begin
            it = exp_q.pop_front();
            if (it.code != code || (code == EV_RX && it.data != data)) begin
                errors++;
                $display("FAIL %s event actual=%0d/%0h expected=%0d/%0h", it.req, code, data, it.code, it.data);
            end
        end
    endtask

    // Monitor: scoreboard pops and R9 line watch
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_match)   sb_take(EV_MATCH, 0);
            if (ev_rx_done) sb_take(EV_RX, int'(byte_buf[15:8]));
            if (ev_tx_ack)  sb_take(EV_ACK, 0);
            if (ev_tx_nak)  sb_take(EV_NAK, 0);
            if (ev_stop)    sb_take(EV_STOP, 0);
            if (sda_oe) sda_seen = 1'b1;
            if (sda_oe != prev_sda_oe && scl_bus) r9_viol++;
            prev_sda_oe = sda_oe;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_bus) @(negedge clk);
        tick(HP);
    endtask

    task automatic scl_down();
        m_scl_low = 1'b1;
        tick(HP);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        tick(HP);
        scl_up();
        m_sda_low = 1'b1;
        tick(HP);
        scl_down();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        tick(HP);
        scl_up();
        m_sda_low = 1'b0;
        tick(HP);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i];
            tick(HP);
            scl_up();
            scl_down();
        end
        m_sda_low = 1'b0;
        tick(HP);
        scl_up();
        ack_n = sda_bus;
        scl_down();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            scl_up();
            b[i] = sda_bus;
            scl_down();
        end
        m_sda_low = give_ack;
        tick(HP);
        scl_up();
        scl_down();
        m_sda_low = 1'b0;
    endtask

    task automatic arm(input logic [7:0] v);
        tx_byte = v;
        tx_go   = 1'b1;
        tick(1);
        tx_go   = 1'b0;
        tick(2);
    endtask

    initial begin
        logic a;
        logic [7:0] got;
        tick(3);
        // R10: reset state
        check(!scl_oe && !sda_oe && byte_buf == 16'h0 &&
              !(ev_match || ev_rx_done || ev_tx_ack || ev_tx_nak || ev_stop),
              "R10", "reset outputs", {scl_oe, sda_oe, byte_buf}, 0);
        rst_n = 1'b1;
        tick(5);

        // R2: disabled responder ignores its own address
        sda_seen = 1'b0;
        bus_start();
        put_byte(8'h54, a);
        check(a == 1'b1, "R2", "ack while disabled", a, 1);
        bus_stop();
        check(!sda_seen && !scl_oe, "R2", "no drive while disabled", sda_seen, 0);

        // R1/R4/R7: write two bytes
        slave_en = 1'b1;
        tick(5);
        expect_evt(EV_MATCH, 0, "R1");
        expect_evt(EV_RX, 8'h54, "R1");
        bus_start();
        put_byte(8'h54, a);
        check(a == 1'b0, "R1", "address ack", a, 0);
        expect_evt(EV_RX, 8'hA5, "R4");
        put_byte(8'hA5, a);
        check(a == 1'b0, "R4", "data ack 1", a, 0);
        check(byte_buf[15:8] == 8'hA5, "R4", "rx buffer", byte_buf[15:8], 8'hA5);
        expect_evt(EV_RX, 8'h3C, "R4");
        put_byte(8'h3C, a);
        check(a == 1'b0, "R4", "data ack 2", a, 0);
        expect_evt(EV_STOP, 0, "R7");
        bus_stop();
        tick(5);
        check(!sda_oe && !scl_oe, "R7", "lines free after stop", {sda_oe, scl_oe}, 0);

        // R5/R6: read two bytes, ACK then NAK
        expect_evt(EV_MATCH, 0, "R1");
        expect_evt(EV_RX, 8'h55, "R1");
        bus_start();
        put_byte(8'h55, a);
        check(a == 1'b0, "R1", "read address ack", a, 0);
        tick(40);
        check(scl_oe && !scl_bus, "R5", "scl held before command", scl_oe, 1);
        expect_evt(EV_ACK, 0, "R6");
        arm(8'hC3);
        check(byte_buf[7:0] == 8'hC3, "R5", "tx buffer", byte_buf[7:0], 8'hC3);
        get_byte(1'b1, got);
        check(got == 8'hC3, "R5", "read byte 1 msb first", got, 8'hC3);
        tick(40);
        check(scl_oe == 1'b1, "R6", "scl held after ack", scl_oe, 1);
        expect_evt(EV_NAK, 0, "R6");
        arm(8'h5A);
        get_byte(1'b0, got);
        check(got == 8'h5A, "R5", "read byte 2", got, 8'h5A);
        tick(10);
        check(!scl_oe && !sda_oe, "R6", "bus free after nak", {scl_oe, sda_oe}, 0);
        expect_evt(EV_STOP, 0, "R7");
        bus_stop();

        // R3: foreign address
        tick(5);
        sda_seen = 1'b0;
        bus_start();
        put_byte(8'h40, a);
        check(a == 1'b1, "R3", "no ack for foreign address", a, 1);
        put_byte(8'hFF, a);
        check(a == 1'b1, "R3", "no ack for foreign data", a, 1);
        check(!sda_seen, "R3", "sda never driven", sda_seen, 0);
        expect_evt(EV_STOP, 0, "R7");
        bus_stop();

        // R8: write then repeated-start read
        tick(5);
        expect_evt(EV_MATCH, 0, "R8");
        expect_evt(EV_RX, 8'h54, "R8");
        bus_start();
        put_byte(8'h54, a);
        expect_evt(EV_RX, 8'h11, "R8");
        put_byte(8'h11, a);
        expect_evt(EV_MATCH, 0, "R8");
        expect_evt(EV_RX, 8'h55, "R8");
        bus_start();
        put_byte(8'h55, a);
        check(a == 1'b0, "R8", "ack after repeated start", a, 0);
        expect_evt(EV_NAK, 0, "R8");
        arm(8'h99);
        get_byte(1'b0, got);
        check(got == 8'h99, "R8", "read after repeated start", got, 8'h99);
        expect_evt(EV_STOP, 0, "R7");
        bus_stop();
        tick(20);

        check(r9_viol == 0, "R9", "sda moved while scl high", r9_viol, 0);
        check(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule